// File: doc/BRIEF.md
# Transmit Block Handshake Sequencer

This block controls the transmit side of a data-mover port. A data source raises a READY level to start a block of packets. The sequencer counts the packet-sent indications coming back from the link. One clock after the last packet of the block has gone out, it returns a one-cycle DONE pulse to the source. The number of packets in a block comes from a control word that software writes.

The READY/DONE handshake runs in one of two modes. In strict mode the source must hold READY until DONE appears. A READY drop before that point is flagged as a protocol error and the block is abandoned. In relaxed mode READY only starts a block, and it may fall at any time afterwards. Alongside the sequencing, the block can advance the low destination offset held in header quadlet 2 of an asynchronous write by the payload size rounded up to a whole quadlet. It passes a speed code to the PHY and latches the acknowledge code that the receiving node returns for transfers made through this port.

All pins are plain control and status signals with no back-pressure. READY acts as a level whose rising edge opens a block. DONE and the error flag are single-cycle pulses, and the source must accept them when they occur.

Top module: `txseq_top`

## Requirements
- R1: After reset, done, proto_err, phy_speed and ack_status are all 0, and every control field is 0, so header quadlet 2 passes through unchanged.
- R2: A write with ctl_wr loads ctl_word using most-significant-first numbering, where field bit k is ctl_word[31-k]. The packet count sits at bits 0..11 (ctl_word[31:20]), strict mode at bit 14 (ctl_word[17]), auto-advance at bit 15 (ctl_word[16]), the speed code at bits 22..23 (ctl_word[9:8]) and header-insert at bit 27 (ctl_word[4]).
- R3: While a block is open, done rises for exactly one cycle after the clock edge that samples the Nth pkt_sent, where N is the packet count. A count of 0 acts as 1.
- R4: A block opens only on a rising edge of src_ready while no block is open. A pkt_sent outside an open block has no effect and produces no done.
- R5: In strict mode, a low src_ready sampled while a block is open gives a one-cycle proto_err pulse and closes the block, and the block's later packets produce no done.
- R6: In relaxed mode, src_ready may fall after the block opens, and done still arrives after the Nth packet. proto_err never rises in relaxed mode.
- R7: When auto-advance, header-insert and tx_async are all 1, hdr_q2_out = (hdr_q2_in + ((pay_size + 3) with its two low bits cleared)) mod 2^32. In every other case hdr_q2_out equals hdr_q2_in.
- R8: phy_speed always shows the speed field most recently written.
- R9: ack_status takes ack_code on a cycle with ack_valid and ack_port both 1, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Load ctl_word into the control fields |
| ctl_word | input | 32 | Control word, MSB-first field numbering |
| tx_async | input | 1 | Current transmit is asynchronous (0 = isochronous) |
| src_ready | input | 1 | READY level from the data source |
| pkt_sent | input | 1 | One packet of the block has been sent |
| pay_size | input | 16 | Payload size in bytes |
| hdr_q2_in | input | 32 | Header quadlet 2 (low destination offset) |
| ack_valid | input | 1 | An acknowledge code is present |
| ack_port | input | 1 | The acknowledged transfer went through this port |
| ack_code | input | 5 | Acknowledge code from the receiving node |
| done | output | 1 | One-cycle DONE pulse to the source |
| proto_err | output | 1 | One-cycle strict-handshake violation pulse |
| hdr_q2_out | output | 32 | Header quadlet 2, advanced when enabled |
| phy_speed | output | 2 | Speed code to the PHY |
| ack_status | output | 5 | Captured acknowledge code |

## Verification
The bench sweeps the packet count from 0 to 6 in both handshake modes. A sequencer that ends one packet early or late, or that treats a count of 0 as 4096, puts DONE in the wrong cycle or never raises it. It drops READY early in each mode, so a design with the modes swapped either raises a false error or lets an abandoned block finish. It also holds READY across DONE to catch a design that restarts on a level instead of an edge. The header adder is swept over sizes 0 to 20 across all eight enable combinations, with offsets near 2^32. This catches a rounding that truncates instead of rounding up, a sum that saturates instead of wrapping, and an advance that ignores one of its three enables.

// File: rtl/txseq_pkg.sv
package txseq_pkg;
  localparam int CNT_W  = 12;
  localparam int SPD_W  = 2;
  localparam int WORD_W = 32;

  // MSB-first field numbering: field bit k lives at word bit (WORD_W-1-k)
  localparam int POS_CNT_HI = WORD_W - 1 - 0;
  localparam int POS_STRICT = WORD_W - 1 - 14;
  localparam int POS_AUTO   = WORD_W - 1 - 15;
  localparam int POS_SPD_HI = WORD_W - 1 - 22;
  localparam int POS_HDRINS = WORD_W - 1 - 27;

  typedef struct packed {
    logic [CNT_W-1:0] blk_pkts;
    logic             strict;
    logic             auto_adv;
    logic             hdr_ins;
    logic [SPD_W-1:0] speed;
  } txseq_cfg_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_OPEN = 1'b1} txseq_state_e;
endpackage

// File: rtl/txseq_cfg_reg.sv
module txseq_cfg_reg
  import txseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  output txseq_cfg_t        cfg
);
  txseq_cfg_t nxt;

  always_comb begin
    nxt.blk_pkts = wr_word[POS_CNT_HI -: CNT_W];
    nxt.strict   = wr_word[POS_STRICT];
    nxt.auto_adv = wr_word[POS_AUTO];
    nxt.hdr_ins  = wr_word[POS_HDRINS];
    nxt.speed    = wr_word[POS_SPD_HI -: SPD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg <= '0;
    else if (wr_en) cfg <= nxt;
  end
endmodule

// File: rtl/txseq_blk_fsm.sv
module txseq_blk_fsm
  import txseq_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strict,
  input  logic [CW-1:0] blk_pkts,
  input  logic          src_ready,
  input  logic          pkt_sent,
  output logic          done,
  output logic          proto_err
);
  txseq_state_e  state;
  logic          ready_q;
  logic [CW-1:0] sent_cnt;
  logic [CW-1:0] last_idx;
  logic          start;

  assign start    = src_ready & ~ready_q;
  assign last_idx = (blk_pkts == '0) ? '0 : blk_pkts - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ready_q   <= 1'b0;
      sent_cnt  <= '0;
      done      <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      ready_q   <= src_ready;
      done      <= 1'b0;
      proto_err <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_OPEN;
            sent_cnt <= '0;
          end
        end
        ST_OPEN: begin
          if (strict && !src_ready) begin
            proto_err <= 1'b1;
            state     <= ST_IDLE;
          end else if (pkt_sent) begin
            if (sent_cnt == last_idx) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              sent_cnt <= sent_cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txseq_hdr_adv.sv
module txseq_hdr_adv #(
  parameter int SIZE_W = 16,
  parameter int HDR_W  = 32
) (
  input  logic              enable,
  input  logic [SIZE_W-1:0] size,
  input  logic [HDR_W-1:0]  hdr_in,
  output logic [HDR_W-1:0]  hdr_out
);
  localparam int RW = SIZE_W + 1;
  logic [RW-1:0]    rounded;
  logic [HDR_W-1:0] step;

  always_comb begin
    rounded = ({1'b0, size} + RW'(3)) & ~RW'(3);
    step    = HDR_W'(rounded);
    hdr_out = enable ? (hdr_in + step) : hdr_in;
  end
endmodule

// File: rtl/txseq_top.sv
module txseq_top
  import txseq_pkg::*;
#(
  parameter int SIZE_W = 16,
  parameter int ACK_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [WORD_W-1:0] ctl_word,
  input  logic              tx_async,
  input  logic              src_ready,
  input  logic              pkt_sent,
  input  logic [SIZE_W-1:0] pay_size,
  input  logic [31:0]       hdr_q2_in,
  input  logic              ack_valid,
  input  logic              ack_port,
  input  logic [ACK_W-1:0]  ack_code,
  output logic              done,
  output logic              proto_err,
  output logic [31:0]       hdr_q2_out,
  output logic [SPD_W-1:0]  phy_speed,
  output logic [ACK_W-1:0]  ack_status
);
  txseq_cfg_t cfg;
  logic       strict_mode;
  logic       adv_en;
  logic       ack_hit;

  txseq_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr), .wr_word(ctl_word), .cfg(cfg)
  );

  assign strict_mode = cfg.strict;
  assign adv_en      = cfg.auto_adv & cfg.hdr_ins & tx_async;
  assign ack_hit     = ack_valid & ack_port;
  assign phy_speed   = cfg.speed;

  txseq_blk_fsm #(.CW(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .strict(strict_mode), .blk_pkts(cfg.blk_pkts),
    .src_ready(src_ready), .pkt_sent(pkt_sent), .done(done), .proto_err(proto_err)
  );

  txseq_hdr_adv #(.SIZE_W(SIZE_W), .HDR_W(32)) u_adv (
    .enable(adv_en), .size(pay_size), .hdr_in(hdr_q2_in), .hdr_out(hdr_q2_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ack_status <= '0;
    else if (ack_hit) ack_status <= ack_code;
  end
endmodule

// File: rtl/txseq_chk.sv
module txseq_chk #(
  parameter int ACK_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             proto_err,
  input logic             pkt_sent,
  input logic             strict_mode,
  input logic             adv_en,
  input logic [31:0]      hdr_q2_in,
  input logic [31:0]      hdr_q2_out,
  input logic             ack_hit,
  input logic [ACK_W-1:0] ack_status
);
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_pkt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(pkt_sent));
  p_err_strict_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(strict_mode));
  p_err_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> !proto_err);
  p_hdr_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_en |-> (hdr_q2_out == hdr_q2_in));
  p_hdr_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en |-> (hdr_q2_out[1:0] == hdr_q2_in[1:0]));
  p_ack_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_hit |=> $stable(ack_status));
endmodule

bind txseq_top txseq_chk #(.ACK_W(ACK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .proto_err(proto_err),
  .pkt_sent(pkt_sent), .strict_mode(strict_mode), .adv_en(adv_en),
  .hdr_q2_in(hdr_q2_in), .hdr_q2_out(hdr_q2_out), .ack_hit(ack_hit),
  .ack_status(ack_status)
);

// File: tb/txseq_top_tb.sv
module txseq_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [31:0] ctl_word = '0;
  logic        tx_async = 1'b0;
  logic        src_ready = 1'b0;
  logic        pkt_sent = 1'b0;
  logic [15:0] pay_size = '0;
  logic [31:0] hdr_q2_in = '0;
  logic        ack_valid = 1'b0;
  logic        ack_port = 1'b0;
  logic [4:0]  ack_code = '0;
  logic        done, proto_err;
  logic [31:0] hdr_q2_out;
  logic [1:0]  phy_speed;
  logic [4:0]  ack_status;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txseq_top u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_word(ctl_word),
    .tx_async(tx_async), .src_ready(src_ready), .pkt_sent(pkt_sent),
    .pay_size(pay_size), .hdr_q2_in(hdr_q2_in), .ack_valid(ack_valid),
    .ack_port(ack_port), .ack_code(ack_code), .done(done),
    .proto_err(proto_err), .hdr_q2_out(hdr_q2_out), .phy_speed(phy_speed),
    .ack_status(ack_status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [31:0] w);
    @(negedge clk); ctl_wr = 1'b1; ctl_word = w;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  function automatic logic [31:0] mk(input int n, input bit strict, input bit aut,
                                     input bit ins, input int spd);
    return (32'(n) << 20) | (32'(strict) << 17) | (32'(aut) << 16) |
           (32'(spd) << 8) | (32'(ins) << 4);
  endfunction

  // drop: 0 hold READY; 1 drop READY right after the block opens
  task automatic run_block(input int n, input bit strict, input bit drop);
    int tgt;
    tgt = (n == 0) ? 1 : n;
    @(negedge clk); src_ready = 1'b1;
    @(negedge clk);
    if (drop) begin
      src_ready = 1'b0;
      @(negedge clk);
      if (strict) chk("R5 err on early drop", 32'(proto_err), 1);
      else        chk("R6 no err in relaxed", 32'(proto_err), 0);
    end
    for (int i = 1; i <= tgt; i++) begin
      pkt_sent = 1'b1;
      @(negedge clk);
      if (drop && strict) chk("R5 abandoned block gives no done", 32'(done), 0);
      else if (drop)      chk("R6 done after drop", 32'(done), 32'(i == tgt));
      else                chk("R3 done timing", 32'(done), 32'(i == tgt));
    end
    pkt_sent = 1'b0;
    @(negedge clk);
    chk("R3 done one cycle", 32'(done), 0);
    src_ready = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] hv [4];
    hv[0] = 32'h0; hv[1] = 32'h1000_0001; hv[2] = 32'hFFFF_FFF0; hv[3] = 32'hFFFF_FFFF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", 32'(done), 0);
    chk("R1 proto_err", 32'(proto_err), 0);
    chk("R1 speed", 32'(phy_speed), 0);
    chk("R1 ack", 32'(ack_status), 0);
    tx_async = 1'b1; pay_size = 16'd5; hdr_q2_in = 32'h100; #1;
    chk("R1 hdr passthrough", hdr_q2_out, 32'h100);

    // R2 / R8 speed field position
    for (int s = 0; s < 4; s++) begin
      wr_ctl(mk(0, 0, 0, 0, s));
      chk("R8 speed", 32'(phy_speed), 32'(s));
    end

    // R3 count sweep, both modes (R2 count/strict positions)
    for (int st = 0; st < 2; st++)
      for (int n = 0; n <= 6; n++) begin
        wr_ctl(mk(n, st[0], 0, 0, 0));
        run_block(n, st[0], 1'b0);
      end

    // R5 strict early drop, R6 relaxed early drop
    wr_ctl(mk(3, 1, 0, 0, 0));
    run_block(3, 1'b1, 1'b1);
    wr_ctl(mk(3, 0, 0, 0, 0));
    run_block(3, 1'b0, 1'b1);

    // R4 pkt_sent with no block open
    @(negedge clk); pkt_sent = 1'b1;
    @(negedge clk); pkt_sent = 1'b0;
    chk("R4 idle pkt ignored", 32'(done), 0);
    // R4 READY held across done: no new block without a rising edge
    wr_ctl(mk(1, 0, 0, 0, 0));
    @(negedge clk); src_ready = 1'b1;
    @(negedge clk); pkt_sent = 1'b1;
    @(negedge clk); pkt_sent = 1'b0;
    chk("R4 first block done", 32'(done), 1);
    @(negedge clk); pkt_sent = 1'b1;
    @(negedge clk); pkt_sent = 1'b0;
    chk("R4 level READY does not reopen", 32'(done), 0);
    src_ready = 1'b0;
    @(negedge clk);

    // R7 header advance sweep over enable combinations
    for (int e = 0; e < 8; e++) begin
      wr_ctl(mk(0, 0, e[0], e[1], 0));
      for (int h = 0; h < 4; h++)
        for (int sz = 0; sz <= 20; sz++) begin
          logic [31:0] exp;
          @(negedge clk);
          tx_async = e[2]; pay_size = 16'(sz); hdr_q2_in = hv[h];
          #1;
          exp = (e == 7) ? hv[h] + 32'(((sz + 3) / 4) * 4) : hv[h];
          chk("R7 header quadlet 2", hdr_q2_out, exp);
        end
    end
    @(negedge clk); tx_async = 1'b1; pay_size = 16'hFFFF; hdr_q2_in = 32'hFFFF_0000; #1;
    chk("R7 wrap at max size", hdr_q2_out, 32'h0000_0000);

    // R9 ack capture
    @(negedge clk); ack_valid = 1'b1; ack_port = 1'b0; ack_code = 5'h1B;
    @(negedge clk); ack_valid = 1'b0;
    chk("R9 ack from other path ignored", 32'(ack_status), 0);
    ack_valid = 1'b1; ack_port = 1'b1; ack_code = 5'h11;
    @(negedge clk); ack_valid = 1'b0;
    chk("R9 ack captured", 32'(ack_status), 32'h11);
    ack_code = 5'h07;
    @(negedge clk);
    chk("R9 ack held", 32'(ack_status), 32'h11);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule